// File: doc/BRIEF.md
# Column-Scan Panel Timing Sequencer

This block paces pixel delivery for a display panel that is scanned one column at a time. It advances only on cycles where an external panel-clock strobe is high. Every frame opens with a long idle interval. Each column then follows the same pattern: a short idle lead, a run of pixel slots with data-valid high, and an idle tail. By default the panel is 320 columns of 240 pixels. Each frame gap is 4235 strobes, each column lead is 20 strobes and each column tail is 35 strobes. A frame therefore takes 98,635 strobes, which is about 63 Hz at a 6.25 MHz strobe rate. The panel needs a strobe rate between 4.85 and 7.00 MHz.

Pixels are 18-bit RGB words that arrive on a valid/ready stream. Ready is offered only in the cycle whose strobe will put a pixel on the bus. If the stream has no word in that slot, the bus repeats its previous value and a sticky underflow flag is set. A single-cycle frame-start pulse marks the first pixel of column 0. Reset puts the sequencer at the start of a frame gap.

Top module: `lcdc_col_timing`

## Requirements
- R1: After reset, `lcd_de`, `frame_start`, `underflow` and `lcd_data` are all 0, and the sequencer is at the first strobe of a frame gap.
- R2: After reset, the first pixel is driven on strobe number FGAP+LEAD+1, counting from 1.
- R3: Within a column there are LEAD strobes with `lcd_de` low, then ROWS strobes with it high, then TAIL strobes with it low. `lcd_de` takes its new value in the clock cycle after the strobe.
- R4: After COLS columns the sequencer returns to a frame gap. The frame period is FGAP+COLS×(LEAD+ROWS+TAIL) strobes.
- R5: `px_ready` is high only in a cycle where `pix_ce` is high and that strobe is a pixel slot.
- R6: When `px_valid` and `px_ready` are both high at a clock edge, `px_data` appears on `lcd_data` in the next cycle.
- R7: In a pixel slot without `px_valid`, `lcd_data` keeps its previous value and `underflow` goes to 1. It then stays at 1 until reset.
- R8: `lcd_data` changes only on an accepted handshake. It holds through gap cycles.
- R9: `frame_start` is high for exactly one clock, in the cycle where the first pixel of column 0 is shown. `lcd_de` is high in that same cycle.
- R10: When `pix_ce` is low, `lcd_de` and `lcd_data` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Panel-clock strobe; the sequencer advances one step per high cycle |
| px_valid | input | 1 | Stream word available |
| px_data | input | 18 | Stream pixel word (RGB) |
| px_ready | output | 1 | Word accepted at this edge if `px_valid` is high |
| lcd_de | output | 1 | Panel data-valid |
| lcd_data | output | 18 | Panel pixel bus |
| frame_start | output | 1 | One-clock pulse on the first pixel of a frame |
| underflow | output | 1 | Sticky: a pixel slot passed with no stream word |

## Verification
The assertions assume that `pix_ce`, `px_valid` and `px_data` are stable through each clock cycle and have known values once reset is released. The stream source is also assumed to follow the valid/ready rule, so `px_data` only matters in handshake cycles. The bench drives every input at the falling edge and changes the source word only after it has been accepted. It covers a steady strobe, a strobe that is high one cycle in three, and `px_valid` gaps that land inside pixel slots. The reset cases include a reset in the middle of a frame.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
   typedef enum logic [1:0] {
      PH_FGAP = 2'd0,
      PH_LEAD = 2'd1,
      PH_PIX  = 2'd2,
      PH_TAIL = 2'd3
   } phase_e;

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/lcdc_seq.sv
module lcdc_seq
   import lcdc_pkg::*;
#(
   parameter int COLS = 320,
   parameter int ROWS = 240,
   parameter int FGAP = 4235,
   parameter int LEAD = 20,
   parameter int TAIL = 35
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   output logic in_pix,
   output logic first_pix
);
   localparam int MAXLEN = max_of4(FGAP, LEAD, ROWS, TAIL);
   localparam int CW     = $clog2(MAXLEN + 1);
   localparam int COLW   = (COLS > 1) ? $clog2(COLS) : 1;

   phase_e            ph_q;
   logic [CW-1:0]     cnt_q;
   logic [COLW-1:0]   col_q;
   logic [CW-1:0]     last_c;
   logic              col_last;

   always_comb begin
      case (ph_q)
         PH_FGAP: last_c = CW'(FGAP - 1);
         PH_LEAD: last_c = CW'(LEAD - 1);
         PH_PIX:  last_c = CW'(ROWS - 1);
         default: last_c = CW'(TAIL - 1);
      endcase
   end

   assign col_last  = (col_q == COLW'(COLS - 1));
   assign in_pix    = (ph_q == PH_PIX);
   assign first_pix = in_pix && (cnt_q == '0) && (col_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_FGAP;
         cnt_q <= '0;
         col_q <= '0;
      end else if (adv) begin
         if (cnt_q != last_c) begin
            cnt_q <= cnt_q + 1'b1;
         end else begin
            cnt_q <= '0;
            case (ph_q)
               PH_FGAP: ph_q <= PH_LEAD;
               PH_LEAD: ph_q <= PH_PIX;
               PH_PIX:  ph_q <= PH_TAIL;
               default: begin
                  if (col_last) begin
                     ph_q  <= PH_FGAP;
                     col_q <= '0;
                  end else begin
                     ph_q  <= PH_LEAD;
                     col_q <= col_q + 1'b1;
                  end
               end
            endcase
         end
      end
   end

   AST_CNT_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= last_c); // R3
   AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      col_q <= COLW'(COLS - 1)); // R4
   AST_FREEZE_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(cnt_q) && $stable(ph_q) && $stable(col_q)); // R10
   AST_GAP_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      adv && ph_q == PH_TAIL && cnt_q == last_c && col_last |=> ph_q == PH_FGAP); // R4
endmodule

// File: rtl/lcdc_pix.sv
module lcdc_pix #(
   parameter int DW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          in_pix,
   input  logic          first_pix,
   input  logic          px_valid,
   input  logic [DW-1:0] px_data,
   output logic          px_ready,
   output logic          lcd_de,
   output logic [DW-1:0] lcd_data,
   output logic          frame_start,
   output logic          underflow
);
   logic slot;
   assign slot     = adv && in_pix;
   assign px_ready = slot;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lcd_de      <= 1'b0;
         lcd_data    <= '0;
         frame_start <= 1'b0;
         underflow   <= 1'b0;
      end else begin
         frame_start <= slot && first_pix;
         if (adv) lcd_de <= in_pix;
         if (slot && px_valid) lcd_data <= px_data;
         if (slot && !px_valid) underflow <= 1'b1;
      end
   end

   AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow); // R7
   AST_FS_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start); // R9
   AST_FS_WITH_DE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> lcd_de); // R9
   AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(px_valid && px_ready) |=> $stable(lcd_data)); // R8
   AST_DE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(lcd_de)); // R10
endmodule

// File: rtl/lcdc_col_timing.sv
module lcdc_col_timing #(
   parameter int COLS = 320,
   parameter int ROWS = 240,
   parameter int FGAP = 4235,
   parameter int LEAD = 20,
   parameter int TAIL = 35,
   parameter int DW   = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_ce,
   input  logic          px_valid,
   input  logic [DW-1:0] px_data,
   output logic          px_ready,
   output logic          lcd_de,
   output logic [DW-1:0] lcd_data,
   output logic          frame_start,
   output logic          underflow
);
   generate
      if (COLS < 1 || ROWS < 1) begin : g_bad_geom
         $error("lcdc_col_timing: COLS and ROWS must be at least 1");
      end
      if (FGAP < 1 || LEAD < 1 || TAIL < 1) begin : g_bad_gap
         $error("lcdc_col_timing: every gap must last at least one strobe");
      end
      if (DW < 1) begin : g_bad_dw
         $error("lcdc_col_timing: DW must be positive");
      end
   endgenerate

   logic in_pix;
   logic first_pix;

   lcdc_seq #(
      .COLS(COLS), .ROWS(ROWS), .FGAP(FGAP), .LEAD(LEAD), .TAIL(TAIL)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (pix_ce),
      .in_pix    (in_pix),
      .first_pix (first_pix)
   );

   lcdc_pix #(.DW(DW)) pix_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .adv         (pix_ce),
      .in_pix      (in_pix),
      .first_pix   (first_pix),
      .px_valid    (px_valid),
      .px_data     (px_data),
      .px_ready    (px_ready),
      .lcd_de      (lcd_de),
      .lcd_data    (lcd_data),
      .frame_start (frame_start),
      .underflow   (underflow)
   );

   AST_READY_ONLY_ON_CE: assert property (@(posedge clk) disable iff (!rst_n)
      px_ready |-> pix_ce); // R5
   AST_READY_DE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      px_ready |=> lcd_de); // R5
endmodule

// File: tb/lcdc_col_timing_tb_top.sv
module lcdc_col_timing_tb_top;
   localparam int COLS = 3;
   localparam int ROWS = 4;
   localparam int FGAP = 5;
   localparam int LEAD = 2;
   localparam int TAIL = 3;
   localparam int DW   = 18;
   localparam int SPAN = LEAD + ROWS + TAIL;
   localparam int FLEN = FGAP + COLS * SPAN;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pix_ce = 1'b0;
   logic          px_valid = 1'b0;
   logic [DW-1:0] px_data = '0;
   logic          px_ready;
   logic          lcd_de;
   logic [DW-1:0] lcd_data;
   logic          frame_start;
   logic          underflow;

   int n_chk = 0;
   int n_bad = 0;

   // bench model state
   int          e_idx = 0;
   int          src = 1;
   logic [DW-1:0] m_data = '0;
   logic        m_de = 1'b0;
   logic        m_uf = 1'b0;
   logic        m_fs = 1'b0;

   always #4 clk = ~clk;

   lcdc_col_timing #(
      .COLS(COLS), .ROWS(ROWS), .FGAP(FGAP), .LEAD(LEAD), .TAIL(TAIL), .DW(DW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .px_valid(px_valid),
      .px_data(px_data), .px_ready(px_ready), .lcd_de(lcd_de),
      .lcd_data(lcd_data), .frame_start(frame_start), .underflow(underflow)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit is_pix(input int e);
      int p, q;
      p = e % FLEN;
      if (p < FGAP) return 1'b0;
      q = (p - FGAP) % SPAN;
      return (q >= LEAD) && (q < LEAD + ROWS);
   endfunction

   function automatic bit is_first(input int e);
      return (e % FLEN) == FGAP + LEAD;
   endfunction

   // Entered at a falling edge; leaves at the next falling edge.
   task automatic step(input bit ce, input bit vld);
      bit slot, hs;
      pix_ce   = ce;
      px_valid = vld;
      px_data  = DW'(src * 7 + 3);
      #1;
      slot = ce && is_pix(e_idx);
      chk(px_ready == slot, "R5 ready", int'(px_ready), int'(slot));
      hs = slot && vld;
      m_fs = slot && is_first(e_idx);
      if (ce) m_de = slot;
      if (hs) begin
         m_data = DW'(src * 7 + 3);
         src++;
      end
      if (slot && !vld) m_uf = 1'b1;
      if (ce) e_idx++;
      @(posedge clk);
      @(negedge clk);
      chk(lcd_de == m_de, ce ? "R3 de" : "R10 de", int'(lcd_de), int'(m_de));
      chk(lcd_data == m_data, hs ? "R6 data" : "R8/R10 data hold",
          int'(lcd_data), int'(m_data));
      chk(underflow == m_uf, "R7 underflow", int'(underflow), int'(m_uf));
      chk(frame_start == m_fs, "R9 frame_start", int'(frame_start), int'(m_fs));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      pix_ce = 1'b0;
      px_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      e_idx = 0;
      m_data = '0;
      m_de = 1'b0;
      m_uf = 1'b0;
      m_fs = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk(lcd_de == 1'b0, "R1 de", int'(lcd_de), 0);
      chk(lcd_data == '0, "R1 data", int'(lcd_data), 0);
      chk(underflow == 1'b0, "R1 underflow", int'(underflow), 0);
      chk(frame_start == 1'b0, "R1 frame_start", int'(frame_start), 0);
      pix_ce = 1'b1;
      #1;
      chk(px_ready == 1'b0, "R1 ready in gap", int'(px_ready), 0);
      pix_ce = 1'b0;
   endtask

   task automatic t_full_frames();
      int first_de, fs_a, fs_b;
      first_de = -1; fs_a = -1; fs_b = -1;
      do_reset();
      for (int i = 0; i < 2 * FLEN + 4; i++) begin
         step(1'b1, 1'b1);
         if (lcd_de && first_de < 0) first_de = e_idx;
         if (frame_start) begin
            if (fs_a < 0) fs_a = e_idx;
            else if (fs_b < 0) fs_b = e_idx;
         end
      end
      chk(first_de == FGAP + LEAD + 1, "R2 first pixel strobe", first_de, FGAP + LEAD + 1);
      chk(fs_b - fs_a == FLEN, "R4 frame period", fs_b - fs_a, FLEN);
   endtask

   task automatic t_gated_ce();
      do_reset();
      for (int i = 0; i < 3 * FLEN + 9; i++) step(i % 3 == 0, 1'b1);
   endtask

   task automatic t_underflow();
      do_reset();
      for (int i = 0; i < FLEN + 6; i++) step(1'b1, (i % 5) != 2);
      chk(underflow == 1'b1, "R7 sticky at end", int'(underflow), 1);
   endtask

   task automatic t_mid_reset();
      do_reset();
      for (int i = 0; i < FGAP + LEAD + 2; i++) step(1'b1, 1'b1);
      do_reset();
      chk(lcd_de == 1'b0, "R1 de after mid reset", int'(lcd_de), 0);
      chk(lcd_data == '0, "R1 data after mid reset", int'(lcd_data), 0);
      for (int i = 0; i < FLEN + 2; i++) step(1'b1, (i % 4) != 1);
   endtask

   initial begin
      t_reset();
      t_full_frames();
      t_gated_ce();
      t_underflow();
      t_mid_reset();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule